// File: doc/BRIEF.md
# Seven-Segment Rotating Ring Sequencer

This block drives a single seven-segment digit so that one lit segment travels around the outer ring of the digit. While the block is parked, only the middle bar is lit. A press of an active-low push button sets the ring spinning, and it keeps spinning lap after lap. A second press does not halt it on the spot. The block remembers the request, lets the current lap run to its end, and then parks again on the middle bar.

A direction switch picks clockwise or counter-clockwise motion. The switch is read at every step, so flipping it mid-lap reverses the motion from the segment that is lit at that moment. A speed switch picks a step period of 200 ms or 100 ms. The step period comes from an internal divider of the system clock, whose frequency is a parameter. The divider is held cleared while the block is parked, so every run starts with a full-length first step.

The button passes through a two-flop synchroniser, and its falling edge is then detected. No further debouncing is done.

Top module: `segRingSequencer`

## Requirements
- R1: After a synchronous reset, and at any time while parked, `seg` equals 7'h40: only bit 6 (the middle bar g) is lit. Reset also parks a running sequence.
- R2: A falling edge on `btnN` while parked starts a run. The first running step lights bit 0 (segment a) within three clock cycles of the edge reaching the input.
- R3: With `dirCw` = 1, each step moves the lit bit upward around the ring, bit 0 to bit 5 (a, b, c, d, e, f), and bit 5 is followed by bit 0.
- R4: With `dirCw` = 0, each step moves the lit bit downward, giving a, f, e, d, c, b, and bit 0 is followed by bit 5.
- R5: Each step lasts 200 ms of clock cycles when `fastSel` = 0 and 100 ms when `fastSel` = 1. The first step after a start lasts one full period.
- R6: A falling edge on `btnN` while running takes effect only at the wrap step, where the ring would return to bit 0. At that step the block parks (7'h40) instead of lighting a.
- R7: A further falling edge on `btnN` while a stop is already pending has no effect. The lap still ends normally and the block parks once.
- R8: The direction is sampled at every step. A change of `dirCw` mid-lap reverses the motion from the current segment, and the new direction decides where the lap ends.
- R9: While running, exactly one of bits 0 to 5 is lit and bit 6 is off.
- R10: While parked, the step divider does not advance the display. `seg` stays 7'h40 for any length of time, whatever `dirCw` and `fastSel` do.
- R11: With no stop pending, the wrap step lights bit 0 again and the run continues into a new lap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency given by parameter CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| btnN | input | 1 | Start/stop push button, active low, asynchronous |
| dirCw | input | 1 | Direction: 1 clockwise, 0 counter-clockwise |
| fastSel | input | 1 | Step period: 0 for 200 ms, 1 for 100 ms |
| seg | output | 7 | Segment enables, active high, bit 0 = a through bit 6 = g |

## Verification
A corrupted ring position shows up at once as a lit bit that is not a ring neighbour of the previous one, or as two lit bits. A wrong run state shows up as the middle bar coming on at the wrong segment or the wrong lap, or failing to come on at all. A divider with a wrong terminal count moves the segment boundaries by a growing amount, so samples taken in the middle of each step drift onto the wrong segment within a few steps. Checks at the wrap step, and directly after a direction flip, expose a mistake in the stop latch or the wrap decision within one lap.

// File: rtl/segRingPkg.sv
package segRingPkg;

  localparam int RING_N = 6;
  localparam int SEG_N  = RING_N + 1;
  localparam int POS_W  = $clog2(RING_N);

  typedef logic [POS_W-1:0] ringPos_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } runState_t;

  typedef struct packed {
    logic runEn;
    logic load;
    logic advance;
    logic goIdle;
  } seqStrobe_t;

endpackage

// File: rtl/segTickGen.sv
module segTickGen #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned SLOW_MS = 200,
  parameter int unsigned FAST_MS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic fast,
  output logic tick
);

  localparam longint unsigned SLOW_CNT = (64'(CLK_HZ) * 64'(SLOW_MS)) / 64'd1000;
  localparam longint unsigned FAST_CNT = (64'(CLK_HZ) * 64'(FAST_MS)) / 64'd1000;
  localparam int CNT_W = (SLOW_CNT > 64'd2) ? $clog2(SLOW_CNT) : 1;
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_CNT - 64'd1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CNT - 64'd1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastVal;

  // Limit picked every cycle, so a speed change acts on the next tick.
  always_comb lastVal = fast ? FAST_LAST : SLOW_LAST;

  assign tick = enable && (cnt >= lastVal);

  always_ff @(posedge clk) begin
    if (rst || !enable) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/segRingDatapath.sv
module segRingDatapath
  import segRingPkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned SLOW_MS = 200,
  parameter int unsigned FAST_MS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strobe,
  input  logic             dirCw,
  input  logic             fastSel,
  output logic             tick,
  output logic             wrapNext,
  output logic [SEG_N-1:0] seg
);

  localparam ringPos_t LAST_POS = ringPos_t'(RING_N - 1);

  ringPos_t pos;
  ringPos_t nextPos;
  logic [RING_N-1:0] ringLit;

  segTickGen #(
    .CLK_HZ (CLK_HZ),
    .SLOW_MS(SLOW_MS),
    .FAST_MS(FAST_MS)
  ) tick_i (
    .clk   (clk),
    .rst   (rst),
    .enable(strobe.runEn),
    .fast  (fastSel),
    .tick  (tick)
  );

  // Neighbour in the selected direction; position 0 is segment a.
  always_comb begin
    if (dirCw) nextPos = (pos == LAST_POS) ? '0 : pos + 1'b1;
    else       nextPos = (pos == '0) ? LAST_POS : pos - 1'b1;
  end

  assign wrapNext = (nextPos == '0);

  always_ff @(posedge clk) begin
    if (rst || strobe.load || strobe.goIdle) pos <= '0;
    else if (strobe.advance)                 pos <= nextPos;
  end

  for (genvar i = 0; i < RING_N; i++) begin : g_ring
    assign ringLit[i] = strobe.runEn && (pos == ringPos_t'(i));
  end

  assign seg = {!strobe.runEn, ringLit};

endmodule

// File: rtl/segRingCtrl.sv
module segRingCtrl
  import segRingPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btnN,
  input  logic       tick,
  input  logic       wrapNext,
  output seqStrobe_t strobe
);

  logic [SYNC_STAGES:0] btnPipe;
  logic btnFall;
  runState_t st, stNext;
  logic load, advance, goIdle;

  always_ff @(posedge clk) begin
    if (rst) btnPipe <= '1;
    else     btnPipe <= {btnPipe[SYNC_STAGES-1:0], btnN};
  end

  assign btnFall = btnPipe[SYNC_STAGES] & ~btnPipe[SYNC_STAGES-1];

  always_comb begin
    stNext  = st;
    load    = 1'b0;
    advance = 1'b0;
    goIdle  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (btnFall) begin
          stNext = ST_RUN;
          load   = 1'b1;
        end
      end
      ST_RUN: begin
        if (tick && wrapNext && btnFall) begin
          goIdle = 1'b1;
          stNext = ST_IDLE;
        end else begin
          advance = tick;
          if (btnFall) stNext = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        // Further presses are ignored while the stop is pending.
        if (tick && wrapNext) begin
          goIdle = 1'b1;
          stNext = ST_IDLE;
        end else begin
          advance = tick;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= stNext;
  end

  always_comb begin
    strobe.runEn   = (st != ST_IDLE);
    strobe.load    = load;
    strobe.advance = advance;
    strobe.goIdle  = goIdle;
  end

endmodule

// File: rtl/segRingSequencer.sv
module segRingSequencer
  import segRingPkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned SLOW_MS     = 200,
  parameter int unsigned FAST_MS     = 100,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btnN,
  input  logic       dirCw,
  input  logic       fastSel,
  output logic [6:0] seg
);

  seqStrobe_t strobe;
  logic tick;
  logic wrapNext;

  segRingCtrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .btnN    (btnN),
    .tick    (tick),
    .wrapNext(wrapNext),
    .strobe  (strobe)
  );

  segRingDatapath #(
    .CLK_HZ (CLK_HZ),
    .SLOW_MS(SLOW_MS),
    .FAST_MS(FAST_MS)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .dirCw   (dirCw),
    .fastSel (fastSel),
    .tick    (tick),
    .wrapNext(wrapNext),
    .seg     (seg)
  );

endmodule

// File: rtl/segRingSequencer_chk.sv
module segRingSequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       dirCw,
  input logic [6:0] seg
);

  function automatic logic [5:0] rotUp(input logic [5:0] x);
    return {x[4:0], x[5]};
  endfunction

  function automatic logic [5:0] rotDown(input logic [5:0] x);
    return {x[0], x[5:1]};
  endfunction

  // R1: reset parks the display on the middle bar
  a_r1_reset_park: assert property (@(posedge clk) rst |=> (seg == 7'h40));

  // R9: one segment lit at all times, middle bar off while on the ring
  a_r9_single_lit: assert property (@(posedge clk) disable iff (rst) $onehot(seg));

  // R3: clockwise step goes to the upward neighbour
  a_r3_cw_step: assert property (@(posedge clk) disable iff (rst)
    ((seg != $past(seg)) && !seg[6] && !$past(seg[6]) && $past(dirCw))
      |-> (seg[5:0] == rotUp($past(seg[5:0]))));

  // R4: counter-clockwise step goes to the downward neighbour
  a_r4_ccw_step: assert property (@(posedge clk) disable iff (rst)
    ((seg != $past(seg)) && !seg[6] && !$past(seg[6]) && !$past(dirCw))
      |-> (seg[5:0] == rotDown($past(seg[5:0]))));

  // R6: parking happens only from the last segment before the wrap
  a_r6_park_at_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(seg[6]) |-> (($past(seg[5]) && $past(dirCw)) || ($past(seg[1]) && !$past(dirCw))));

  // R2: a run always begins on segment a
  a_r2_start_on_a: assert property (@(posedge clk) disable iff (rst)
    $fell(seg[6]) |-> (seg == 7'h01));

endmodule

bind segRingSequencer segRingSequencer_chk chk_i (
  .clk  (clk),
  .rst  (rst),
  .dirCw(dirCw),
  .seg  (seg)
);

// File: tb/segRingSequencer_tb_top.sv
module segRingSequencer_tb_top;

  localparam int unsigned CLK_HZ = 1000;
  localparam int SLOW_LIM = 200;
  localparam int FAST_LIM = 100;

  // {dir[37], fast[36], stopStep[35:32], eight expected step codes, step 0 lowest}
  // code 0..5 = ring bit index, 6 = middle bar
  localparam logic [37:0] VEC [6] = '{
    {1'b1, 1'b0, 4'd1, 32'h66543210},
    {1'b0, 1'b0, 4'd1, 32'h66123450},
    {1'b1, 1'b1, 4'd0, 32'h66543210},
    {1'b1, 1'b1, 4'd6, 32'h10543210},
    {1'b0, 1'b1, 4'd5, 32'h66123450},
    {1'b1, 1'b0, 4'd5, 32'h66543210}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnN = 1'b1;
  logic dirCw = 1'b1;
  logic fastSel = 1'b0;
  logic [6:0] seg;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  segRingSequencer #(
    .CLK_HZ(CLK_HZ)
  ) dut_i (
    .clk    (clk),
    .rst    (rst),
    .btnN   (btnN),
    .dirCw  (dirCw),
    .fastSel(fastSel),
    .seg    (seg)
  );

  function automatic logic [6:0] codeOf(input logic [3:0] n);
    return (n == 4'd6) ? 7'h40 : 7'(1 << n);
  endfunction

  task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic press();
    @(negedge clk) btnN = 1'b0;
    repeat (4) @(negedge clk);
    btnN = 1'b1;
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitNeg(3);
    rst = 1'b0;
    waitNeg(2);
    check("R1 reset state", seg, 7'h40);

    // R10: long idle with inputs wiggling
    for (int k = 0; k < 4; k++) begin
      dirCw = k[0];
      fastSel = k[1];
      waitNeg(250);
      check("R10 idle hold", seg, 7'h40);
    end

    // Lap table
    for (int e = 0; e < 6; e++) begin
      logic dirV, fastV;
      logic [3:0] stopStep;
      int lim;
      dirV = VEC[e][37];
      fastV = VEC[e][36];
      stopStep = VEC[e][35:32];
      lim = fastV ? FAST_LIM : SLOW_LIM;
      dirCw = dirV;
      fastSel = fastV;
      press();
      waitNeg(lim / 2);
      for (int s = 0; s < 8; s++) begin
        logic [3:0] n;
        string tag;
        n = VEC[e][4*s +: 4];
        if (s == 0) tag = "R2";
        else if (n == 4'd6) tag = "R6";
        else if (s >= 6) tag = "R11";
        else tag = dirV ? "R3" : "R4";
        check($sformatf("%s R5 entry %0d step %0d fast=%0d", tag, e, s, fastV), seg, codeOf(n));
        if (n != 4'd6) begin
          total++;
          if ($countones(seg) != 1 || seg[6]) begin
            bad++;
            $display("FAIL R9 got=%h exp=one ring bit", seg);
          end
        end
        if (s == int'(stopStep)) begin
          press();
          waitNeg(lim - 5);
        end else begin
          waitNeg(lim);
        end
      end
      waitNeg(6 * lim);
      check($sformatf("R6 parked after entry %0d", e), seg, 7'h40);
    end

    // R8 reversal mid-lap, then R7 double stop request
    dirCw = 1'b1;
    fastSel = 1'b0;
    press();
    waitNeg(SLOW_LIM / 2);
    check("R8 pre a", seg, 7'h01);
    waitNeg(SLOW_LIM);
    check("R8 pre b", seg, 7'h02);
    waitNeg(SLOW_LIM);
    check("R8 pre c", seg, 7'h04);
    dirCw = 1'b0;
    waitNeg(SLOW_LIM);
    check("R8 reversed b", seg, 7'h02);
    waitNeg(SLOW_LIM);
    check("R8 R11 reversed a", seg, 7'h01);
    waitNeg(SLOW_LIM);
    check("R8 reversed f", seg, 7'h20);
    press();
    waitNeg(SLOW_LIM - 5);
    check("R7 e", seg, 7'h10);
    press();
    waitNeg(SLOW_LIM - 5);
    check("R7 d", seg, 7'h08);
    waitNeg(SLOW_LIM);
    check("R7 c", seg, 7'h04);
    waitNeg(SLOW_LIM);
    check("R7 b", seg, 7'h02);
    waitNeg(SLOW_LIM);
    check("R7 R6 parked", seg, 7'h40);
    waitNeg(3 * SLOW_LIM);
    check("R7 stays parked", seg, 7'h40);

    // R1: reset during a run
    dirCw = 1'b1;
    press();
    waitNeg(SLOW_LIM + SLOW_LIM / 2);
    check("R1 running b", seg, 7'h02);
    rst = 1'b1;
    waitNeg(3);
    rst = 1'b0;
    waitNeg(1);
    check("R1 reset parks", seg, 7'h40);
    waitNeg(2 * SLOW_LIM);
    check("R1 R10 still parked", seg, 7'h40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule